// File: doc/BRIEF.md
# SDRAM Low-Power Entry Sequencer

This block runs alongside an SDRAM command engine. It decides when the memory enters a low-power state and when it leaves it. A configuration input selects the state: off, self-refresh, power-down or deep power-down. A second configuration input selects an idle delay. Three more fields hold the extended-mode settings: partial-array refresh, temperature-compensated refresh and drive strength.

While the block is active, it counts idle cycles. A cycle is idle when no transfer is in progress and no access is requested. When the count reaches the selected delay, the block asks the command engine to issue the entry command. Before a self-refresh entry, it first sends an extended-mode-register write, but only if the extended-mode fields have changed since they were last written. While the device is in low power, the block drives clock-enable low. In self-refresh and deep power-down it also gates the memory clock.

An access request wakes the device. Clock-enable is held high for a fixed number of exit cycles, and then the request is granted. After the access, the idle countdown starts again, so the low-power state is re-entered after every access.

Commands leave the block on a valid/ready stream. Once `cmd_valid` is raised, it stays high until `cmd_ready` is seen, and the opcode and payload stay stable. The engine may stall the stream for as long as it needs. The device stays clocked and awake while a command is waiting. Access requests use `req_valid`/`req_ready`. A request must be held until it is granted. The grant takes place in a cycle where both are high.

Top module: `sdram_lp_seq`

## Requirements
- R1: With mode 0 (off), no command is ever issued, and `cke` and `clk_en` stay high for any length of idle time.
- R2: With mode 1 (self-refresh), the entry command has opcode 2. After it is accepted, `cke` and `clk_en` are both low.
- R3: In any low-power state, a held `req_valid` raises `cke` in the next cycle. After the access completes and the delay expires again, the same entry command is issued again.
- R4: With mode 2 (power-down), the entry command has opcode 3. After it is accepted, `cke` is low and `clk_en` stays high.
- R5: For an idle-delay setting of 0, 1 or 2, the first cycle with `cmd_valid` high is 1, 65 or 129 cycles after the first idle cycle. Any `xfer_busy` or `req_valid` cycle restarts the count from zero.
- R6: Idle-delay setting 3 behaves exactly like setting 0.
- R7: After `init_done` is high, any difference between the extended-mode fields and the last-written copy causes a write before self-refresh entry. The write has opcode 1 and a payload with partial-array in bits [2:0], temperature compensation in [4:3] and drive strength in [6:5]. The write is followed directly by the self-refresh entry command. While `init_done` is low, the fields are taken as already written. An unchanged set causes no write.
- R8: While `bus_shared` is high, no extended-mode write is issued. A change made during that time is written at the first self-refresh entry after `bus_shared` falls.
- R9: With mode 3 (deep power-down), the entry command has opcode 4, and then `cke` and `clk_en` are low. The device leaves that state only on an access request. `reinit_req` is high for exactly the first exit cycle.
- R10: On exit, `cke` is high for `EXIT_CYC` cycles with `req_ready` low, and then `req_ready` rises. `req_ready` is only ever high while `cke` is high.
- R11: A stalled command keeps `cmd_valid`, `cmd_op` and `cmd_emr` unchanged, and `cke` stays high until the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Low-power mode: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfg_idle_sel | input | 2 | Idle delay: 0 none, 1 64 cycles, 2 128 cycles, 3 same as 0 |
| cfg_pasr | input | 3 | Partial-array refresh field |
| cfg_tcsr | input | 2 | Temperature-compensated refresh field |
| cfg_ds | input | 2 | Drive-strength field |
| init_done | input | 1 | Device initialization complete |
| bus_shared | input | 1 | Strap: SDRAM bus shared with another controller |
| xfer_busy | input | 1 | A transfer is in progress |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Access may be granted |
| cmd_valid | output | 1 | Command pending |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 3 | 1 ext-mode write, 2 self-refresh, 3 power-down, 4 deep power-down |
| cmd_emr | output | 7 | Extended-mode payload |
| cke | output | 1 | SDRAM clock enable |
| clk_en | output | 1 | SDRAM clock gate, low stops the clock |
| reinit_req | output | 1 | One-cycle pulse: device must be re-initialized |

## Verification
The hardest case to reach is a changed extended-mode field that must survive a period in which its write is suppressed. The stimulus first changes drive strength while `bus_shared` is high and checks that only the self-refresh entry is issued. It then wakes the device, clears the strap and expects the delayed write with the new payload. Stalling `cmd_ready` while a write is pending checks that the payload holds and the device stays awake. A queue of expected opcodes and payloads then catches any write that is missing, repeated or extra.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;
  localparam int PASR_W = 3;
  localparam int TCSR_W = 2;
  localparam int DS_W   = 2;
  localparam int EMR_W  = PASR_W + TCSR_W + DS_W;

  typedef enum logic [1:0] {
    LPM_OFF  = 2'd0,
    LPM_SREF = 2'd1,
    LPM_PDN  = 2'd2,
    LPM_DPD  = 2'd3
  } lpm_e;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_EMRS = 3'd1,
    OP_SREF = 3'd2,
    OP_PDN  = 3'd3,
    OP_DPD  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_EMR  = 3'd1,
    ST_ENT  = 3'd2,
    ST_LP   = 3'd3,
    ST_EXIT = 3'd4
  } st_e;
endpackage

// File: rtl/sdlp_idle_timer.sv
module sdlp_idle_timer #(
  parameter int D1 = 64,
  parameter int D2 = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic [1:0] sel,
  output logic       hit
);
  localparam int CW = $clog2(D2 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  // setting 3 is reserved and folds onto the no-delay setting
  always_comb begin
    case (sel)
      2'd1:    limit = CW'(D1);
      2'd2:    limit = CW'(D2);
      default: limit = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!idle)        cnt <= '0;
    else if (cnt != limit) cnt <= cnt + CW'(1);
  end

  assign hit = idle && (cnt == limit);

  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (cnt == '0)); // R5
endmodule

// File: rtl/sdlp_emr_track.sv
module sdlp_emr_track
  import sdlp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic [EMR_W-1:0] cfg_word,
  input  logic             commit,
  input  logic [EMR_W-1:0] commit_word,
  output logic             dirty
);
  logic [EMR_W-1:0] shadow;

  // before init the engine writes the fields itself, so the copy follows them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shadow <= '0;
    else if (!init_done) shadow <= cfg_word;
    else if (commit)     shadow <= commit_word;
  end

  assign dirty = init_done && (cfg_word != shadow);

  AST_NO_DIRTY_PREINIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> (shadow == $past(cfg_word))); // R7
endmodule

// File: rtl/sdlp_ctrl.sv
module sdlp_ctrl
  import sdlp_pkg::*;
#(
  parameter int EXIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [EMR_W-1:0] cfg_word,
  input  logic             init_done,
  input  logic             bus_shared,
  input  logic             idle_hit,
  input  logic             dirty,
  input  logic             req_valid,
  input  logic             cmd_ready,
  output logic             active,
  output logic             emr_commit,
  output logic [EMR_W-1:0] emr_word,
  output logic             req_ready,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [EMR_W-1:0] cmd_emr,
  output logic             cke,
  output logic             clk_en,
  output logic             reinit_req
);
  localparam int XW = $clog2(EXIT_CYC + 1);

  st_e              state, nst;
  lpm_e             mode_q;
  op_e              op_q;
  logic [EMR_W-1:0] emr_q;
  logic [XW-1:0]    exit_cnt;
  logic             reinit_q;

  function automatic op_e entry_op(lpm_e m);
    case (m)
      LPM_SREF: return OP_SREF;
      LPM_PDN:  return OP_PDN;
      LPM_DPD:  return OP_DPD;
      default:  return OP_IDLE;
    endcase
  endfunction

  logic want_lp, want_emr;
  assign want_lp  = init_done && idle_hit && (lpm_e'(cfg_mode) != LPM_OFF);
  assign want_emr = (lpm_e'(cfg_mode) == LPM_SREF) && dirty && !bus_shared;

  always_comb begin
    nst = state;
    case (state)
      ST_ACT:  if (want_lp) nst = want_emr ? ST_EMR : ST_ENT;
      ST_EMR:  if (cmd_ready) nst = ST_ENT;
      ST_ENT:  if (cmd_ready) nst = ST_LP;
      ST_LP:   if (req_valid) nst = ST_EXIT;
      ST_EXIT: if (exit_cnt == '0) nst = ST_ACT;
      default: nst = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ACT;
      mode_q   <= LPM_OFF;
      op_q     <= OP_IDLE;
      emr_q    <= '0;
      exit_cnt <= '0;
      reinit_q <= 1'b0;
    end else begin
      state    <= nst;
      reinit_q <= (state == ST_LP) && req_valid && (mode_q == LPM_DPD);
      case (state)
        ST_ACT: if (want_lp) begin
          mode_q <= lpm_e'(cfg_mode);
          if (want_emr) begin
            op_q  <= OP_EMRS;
            emr_q <= cfg_word;
          end else begin
            op_q <= entry_op(lpm_e'(cfg_mode));
          end
        end
        ST_EMR:  if (cmd_ready) op_q <= entry_op(mode_q);
        ST_LP:   if (req_valid) exit_cnt <= XW'(EXIT_CYC - 1);
        ST_EXIT: if (exit_cnt != '0) exit_cnt <= exit_cnt - XW'(1);
        default: ;
      endcase
    end
  end

  assign active     = (state == ST_ACT);
  assign req_ready  = (state == ST_ACT);
  assign cmd_valid  = (state == ST_EMR) || (state == ST_ENT);
  assign cmd_op     = op_q;
  assign cmd_emr    = emr_q;
  assign emr_commit = (state == ST_EMR) && cmd_ready;
  assign emr_word   = emr_q;
  assign cke        = (state != ST_LP);
  assign clk_en     = !((state == ST_LP) && (mode_q != LPM_PDN));
  assign reinit_req = reinit_q;

  AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && lpm_e'(cfg_mode) == LPM_OFF) |=> (state == ST_ACT)); // R1
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LP && req_valid) |=> cke); // R3
  AST_EMR_THEN_SREF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMR && cmd_ready) |=> (cmd_valid && cmd_op == OP_SREF)); // R7
  AST_NO_EMR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && bus_shared) |=> (state != ST_EMR)); // R8
  AST_REINIT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |-> ($past(state) == ST_LP && $past(mode_q) == LPM_DPD)); // R9
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_emr) && cke)); // R11
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdlp_pkg::*;
#(
  parameter int DELAY1   = 64,
  parameter int DELAY2   = 128,
  parameter int EXIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_idle_sel,
  input  logic [2:0] cfg_pasr,
  input  logic [1:0] cfg_tcsr,
  input  logic [1:0] cfg_ds,
  input  logic       init_done,
  input  logic       bus_shared,
  input  logic       xfer_busy,
  input  logic       req_valid,
  output logic       req_ready,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [2:0] cmd_op,
  output logic [6:0] cmd_emr,
  output logic       cke,
  output logic       clk_en,
  output logic       reinit_req
);
  logic [EMR_W-1:0] cfg_word, emr_word;
  logic active, idle, idle_hit, dirty, emr_commit;

  assign cfg_word = {cfg_ds, cfg_tcsr, cfg_pasr};
  assign idle     = active && !xfer_busy && !req_valid;

  sdlp_idle_timer #(.D1(DELAY1), .D2(DELAY2)) u_timer (
    .clk(clk), .rst_n(rst_n), .idle(idle), .sel(cfg_idle_sel), .hit(idle_hit)
  );

  sdlp_emr_track u_emr (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .cfg_word(cfg_word),
    .commit(emr_commit), .commit_word(emr_word), .dirty(dirty)
  );

  sdlp_ctrl #(.EXIT_CYC(EXIT_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_word(cfg_word),
    .init_done(init_done), .bus_shared(bus_shared), .idle_hit(idle_hit),
    .dirty(dirty), .req_valid(req_valid), .cmd_ready(cmd_ready),
    .active(active), .emr_commit(emr_commit), .emr_word(emr_word),
    .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_emr(cmd_emr), .cke(cke), .clk_en(clk_en), .reinit_req(reinit_req)
  );

  AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cke); // R10
  AST_GATE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !cke); // R2
endmodule

// File: tb/sim_sdram_lp_seq.sv
module sim_sdram_lp_seq;
  localparam int EXIT_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_idle_sel = 2'd0, cfg_tcsr = 2'd0, cfg_ds = 2'd0;
  logic [2:0] cfg_pasr = 3'd1;
  logic init_done = 1'b0, bus_shared = 1'b0, xfer_busy = 1'b0, req_valid = 1'b0;
  logic cmd_ready = 1'b1;
  logic req_ready, cmd_valid, cke, clk_en, reinit_req;
  logic [2:0] cmd_op;
  logic [6:0] cmd_emr;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [9:0] expq[$];

  always #2.5 clk = ~clk;

  sdram_lp_seq #(.EXIT_CYC(EXIT_CYC)) u0 (.*);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver side of the scoreboard: expected {opcode, payload}
  task automatic expect_cmd(logic [2:0] op, logic [6:0] emr);
    expq.push_back({op, emr});
  endtask

  // monitor: a handshake happens at the next edge
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7 unexpected command", int'(cmd_op), 0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        check(cmd_op == e[9:7], "R2/R4/R9 opcode", int'(cmd_op), int'(e[9:7]));
        if (e[9:7] == 3'd1)
          check(cmd_emr == e[6:0], "R7 payload", int'(cmd_emr), int'(e[6:0]));
      end
    end
  end

  // access while awake or asleep; leaves xfer_busy high
  task automatic access(bit asleep, bit exp_reinit);
    int n;
    req_valid = 1'b1;
    if (asleep) begin
      step();
      check(cke == 1'b1, "R3 wake cke", int'(cke), 1);
      check(reinit_req == exp_reinit, "R9 reinit pulse", int'(reinit_req), int'(exp_reinit));
      check(req_ready == 1'b0, "R10 ready low in exit", int'(req_ready), 0);
      n = 0;
      while (!req_ready && n < 50) begin step(); n++; end
      check(n == EXIT_CYC, "R10 exit length", n, EXIT_CYC);
      check(reinit_req == 1'b0, "R9 pulse width", int'(reinit_req), 0);
    end else begin
      n = 0;
      while (!req_ready && n < 50) begin step(); n++; end
    end
    step();
    req_valid = 1'b0;
    xfer_busy = 1'b1;
    step();
  endtask

  task automatic measure(int exp, string tag);
    int n = 0;
    xfer_busy = 1'b0;
    do begin step(); n++; end while (!cmd_valid && n < 400);
    check(n == exp, tag, n, exp);
  endtask

  task automatic settle_lp();
    int n = 0;
    while (cke && n < 20) begin step(); n++; end
    check(cke == 1'b0, "R2/R4 cke low", int'(cke), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check(cke && clk_en && req_ready && !cmd_valid, "R10 reset state", int'(cke), 1);
    repeat (2) step();
    init_done = 1'b1;

    // R1: mode off never sleeps
    for (int i = 0; i < 200; i++) begin
      step();
      if (cmd_valid || !cke) check(1'b0, "R1 no entry", int'(cmd_valid), 0);
    end
    check(cke && clk_en, "R1 awake", int'(cke), 1);

    // R4/R5: power-down, no delay
    access(1'b0, 1'b0);
    cfg_mode = 2'd2;
    expect_cmd(3'd3, 7'd0);
    measure(1, "R5 delay 0");
    settle_lp();
    check(clk_en == 1'b1, "R4 clock running", int'(clk_en), 1);

    // R3/R10: wake then re-entry after 64 cycles
    access(1'b1, 1'b0);
    cfg_idle_sel = 2'd1;
    expect_cmd(3'd3, 7'd0);
    measure(65, "R5 delay 64 / R3 re-entry");
    settle_lp();

    access(1'b1, 1'b0);
    cfg_idle_sel = 2'd2;
    expect_cmd(3'd3, 7'd0);
    measure(129, "R5 delay 128");
    settle_lp();

    access(1'b1, 1'b0);
    cfg_idle_sel = 2'd3;
    expect_cmd(3'd3, 7'd0);
    measure(1, "R6 reserved delay");
    settle_lp();

    // R5: a transfer during the countdown restarts it
    access(1'b1, 1'b0);
    cfg_idle_sel = 2'd1;
    xfer_busy = 1'b0;
    repeat (30) step();
    check(cmd_valid == 1'b0, "R5 still counting", int'(cmd_valid), 0);
    xfer_busy = 1'b1;
    step();
    expect_cmd(3'd3, 7'd0);
    measure(65, "R5 restart");
    settle_lp();

    // R7/R11/R2: changed field, stalled write, then self-refresh
    access(1'b1, 1'b0);
    cfg_idle_sel = 2'd0;
    cfg_mode = 2'd1;
    cfg_pasr = 3'd5;
    cmd_ready = 1'b0;
    expect_cmd(3'd1, {2'd0, 2'd0, 3'd5});
    expect_cmd(3'd2, 7'd0);
    measure(1, "R7 write issued");
    repeat (5) step();
    check(cmd_valid && cmd_op == 3'd1, "R11 held", int'(cmd_op), 1);
    check(cke == 1'b1, "R11 awake while stalled", int'(cke), 1);
    cmd_ready = 1'b1;
    settle_lp();
    check(clk_en == 1'b0, "R2 clock gated", int'(clk_en), 0);

    // R7: unchanged fields, no second write
    access(1'b1, 1'b0);
    expect_cmd(3'd2, 7'd0);
    measure(1, "R7 no repeat");
    settle_lp();

    // R8: shared bus suppresses write, released later
    access(1'b1, 1'b0);
    bus_shared = 1'b1;
    cfg_ds = 2'd2;
    expect_cmd(3'd2, 7'd0);
    measure(1, "R8 suppressed");
    settle_lp();
    access(1'b1, 1'b0);
    bus_shared = 1'b0;
    expect_cmd(3'd1, {2'd2, 2'd0, 3'd5});
    expect_cmd(3'd2, 7'd0);
    measure(1, "R8 deferred write");
    settle_lp();

    // R9: deep power-down
    access(1'b1, 1'b0);
    cfg_mode = 2'd3;
    expect_cmd(3'd4, 7'd0);
    measure(1, "R9 entry");
    settle_lp();
    check(clk_en == 1'b0, "R9 clock gated", int'(clk_en), 0);
    repeat (20) step();
    check(cke == 1'b0, "R9 stays down", int'(cke), 0);
    access(1'b1, 1'b1);
    xfer_busy = 1'b0;
    cfg_mode = 2'd0;
    step();

    check(expq.size() == 0, "R7 scoreboard drained", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R10 watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule